// File: doc/BRIEF.md
# Event Counter Input Conditioner

This block turns a raw external count pin into a clean, single-cycle count enable for a timer channel. The pin is first brought into the system clock domain through a short synchronizer chain. A noise rejector can then be switched in; it holds the last accepted level and adopts a new one only after a slow sampling strobe has marked two of its falling edges while the pin stayed at that new level. An edge detector then picks out either rising or falling transitions of the conditioned level, as chosen by a polarity control.

A mode control selects what reaches the counter. In event mode the output follows the conditioned pin edges. In timer mode it follows an internal prescaled tick, and the polarity and filter controls play no part. The counter, the prescaler, the register interface and the joining of two channels into a wider timer sit outside this block. The mode choice still applies to a channel that is part of such a joined pair.

Top module: `evc_conditioner`

## Requirements
- R1: With `mode_evt` = 0 (timer mode), each cycle in which `tick_in` is high produces `count_en` high in the following cycle, including back-to-back ticks.
- R2: With `mode_evt` = 1, `pol_rise` = 1 selects 0-to-1 transitions of the pin as count events, and `pol_rise` = 0 selects 1-to-0 transitions; the other direction produces no pulse.
- R3: With `filt_en` = 0 in event mode, a qualifying pin transition applied in cycle N raises `count_en` in cycle N+3 (two synchronizer stages plus the output register).
- R4: With `filt_en` = 1, a changed level is adopted on the second cycle in which `strobe_2k` is high after the synchronized pin has differed from the held level; a qualifying transition then raises `count_en` two cycles after that second strobe cycle, and never after the first.
- R5: With `filt_en` = 1, a pin change that returns to the held level before the second strobe is discarded: neither edge of the glitch produces a pulse, and later strobes do not revive it.
- R6: In timer mode the pin, `pol_rise` and `filt_en` have no effect on `count_en`.
- R7: After reset `count_en` is low, and with the pin at its idle level (`IDLE_LEVEL`, default 1) no pulse appears when reset is released.
- R8: Changing `pol_rise` while the conditioned level is steady produces no pulse.
- R9: In event mode `tick_in` has no effect on `count_en`.
- R10: Each accepted edge yields exactly one `count_en` cycle; pin toggles two cycles apart give separate single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external count input |
| strobe_2k | input | 1 | One-cycle pulse marking each falling edge of the slow sampling clock |
| tick_in | input | 1 | One-cycle internal prescaled count enable |
| mode_evt | input | 1 | 1: event mode, 0: timer mode |
| pol_rise | input | 1 | 1: rising edge counts, 0: falling edge counts |
| filt_en | input | 1 | 1: noise rejector in path, 0: direct |
| count_en | output | 1 | Registered one-cycle count enable |

## Verification
The properties assume `tick_in` and `strobe_2k` are single-cycle pulses aligned to `clk`, that both stay low during reset, and that the pin sits at its idle level while reset is held. The stimulus drives every input on the falling clock edge, holds strobes and ticks for exactly one cycle, and leaves at least four cycles between a pin change and the first strobe meant to count it, so each expected pulse cycle is known exactly. Controls are only switched while the pin and held level agree, which keeps the filter enable from introducing an edge of its own.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  typedef enum logic {
    SRC_TICK  = 1'b0,
    SRC_EVENT = 1'b1
  } count_src_e;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= INIT;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{INIT}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/evc_noise_filter.sv
module evc_noise_filter #(
  parameter int   ACCEPT_STROBES = 2,
  parameter logic INIT           = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic strobe,
  output logic level_out
);

  localparam int CW = (ACCEPT_STROBES > 2) ? $clog2(ACCEPT_STROBES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACCEPT_STROBES - 1);

  logic          held_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= INIT;
      cnt_q  <= '0;
    end else if (level_in == held_q) begin
      cnt_q <= '0;
    end else if (strobe) begin
      if (cnt_q == LAST) begin
        held_q <= level_in;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_out = held_q;

endmodule

// File: rtl/evc_edge_detect.sv
module evc_edge_detect
  import evc_pkg::*;
#(
  parameter logic INIT = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  edge_sel_e sel,
  output logic      hit
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= level;
  end

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = level & ~prev_q;
      default:   hit = ~level & prev_q;
    endcase
  end

endmodule

// File: rtl/evc_conditioner.sv
module evc_conditioner
  import evc_pkg::*;
#(
  parameter int   SYNC_STAGES    = 2,
  parameter int   ACCEPT_STROBES = 2,
  parameter logic IDLE_LEVEL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic strobe_2k,
  input  logic tick_in,
  input  logic mode_evt,
  input  logic pol_rise,
  input  logic filt_en,
  output logic count_en
);

  logic       sync_lvl;
  logic       held_lvl;
  logic       cond_lvl;
  logic       edge_hit;
  edge_sel_e  edge_sel;
  count_src_e src_sel;
  logic       count_q;

  evc_sync #(
    .STAGES (SYNC_STAGES),
    .INIT   (IDLE_LEVEL)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_lvl)
  );

  evc_noise_filter #(
    .ACCEPT_STROBES (ACCEPT_STROBES),
    .INIT           (IDLE_LEVEL)
  ) u_filter (
    .clk       (clk),
    .rst       (rst),
    .level_in  (sync_lvl),
    .strobe    (strobe_2k),
    .level_out (held_lvl)
  );

  assign cond_lvl = filt_en ? held_lvl : sync_lvl;
  assign edge_sel = edge_sel_e'(pol_rise);
  assign src_sel  = count_src_e'(mode_evt);

  evc_edge_detect #(
    .INIT (IDLE_LEVEL)
  ) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (cond_lvl),
    .sel   (edge_sel),
    .hit   (edge_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= 1'b0;
    end else begin
      unique case (src_sel)
        SRC_EVENT: count_q <= edge_hit;
        default:   count_q <= tick_in;
      endcase
    end
  end

  assign count_en = count_q;

endmodule

// File: rtl/evc_conditioner_chk.sv
module evc_conditioner_chk (
  input logic clk,
  input logic rst,
  input logic tick_in,
  input logic strobe_2k,
  input logic mode_evt,
  input logic pol_rise,
  input logic count_en,
  input logic sync_lvl,
  input logic held_lvl,
  input logic cond_lvl,
  input logic edge_hit
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1 / R6: timer mode forwards the tick one cycle later
  p_timer_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(mode_evt)) |-> (count_en == $past(tick_in)));

  // R9: event mode follows detected edges only
  p_event_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode_evt)) |-> (count_en == $past(edge_hit)));

  // R4: the held level moves only on a strobe and only to the synchronized level
  p_held_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && (held_lvl != $past(held_lvl))) |->
      ($past(strobe_2k) && (held_lvl == $past(sync_lvl))));

  // R8: an edge needs a change of the conditioned level
  p_edge_needs_change_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && edge_hit) |-> (cond_lvl != $past(cond_lvl)));

  // R10: one cycle per accepted edge under a steady polarity
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && count_en && mode_evt && $past(mode_evt) && $stable(pol_rise))
      |=> !count_en);

endmodule

bind evc_conditioner evc_conditioner_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_in   (tick_in),
  .strobe_2k (strobe_2k),
  .mode_evt  (mode_evt),
  .pol_rise  (pol_rise),
  .count_en  (count_en),
  .sync_lvl  (sync_lvl),
  .held_lvl  (held_lvl),
  .cond_lvl  (cond_lvl),
  .edge_hit  (edge_hit)
);

// File: tb/evc_conditioner_test.sv
`timescale 1ns/1ps
module evc_conditioner_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_in = 1'b1;
  logic strobe_2k = 1'b0;
  logic tick_in = 1'b0;
  logic mode_evt = 1'b0;
  logic pol_rise = 1'b0;
  logic filt_en = 1'b0;
  logic count_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  evc_conditioner uut (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .strobe_2k (strobe_2k),
    .tick_in   (tick_in),
    .mode_evt  (mode_evt),
    .pol_rise  (pol_rise),
    .filt_en   (filt_en),
    .count_en  (count_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input string tag);
    exp_q.push_back(at);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares every pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() != 0 && exp_q[0] < cyc) begin
        checks++; fails++;
        $display("FAIL %s: missing pulse, actual count_en=0 at %0d, expected 1 at %0d",
                 exp_tag[0], cyc, exp_q[0]);
        void'(exp_q.pop_front()); void'(exp_tag.pop_front());
      end
      if (count_en) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2/R5/R6/R8/R9/R10: unexpected pulse, actual 1 at %0d, expected 0", cyc);
        end else if (exp_q[0] != cyc) begin
          fails++;
          $display("FAIL %s: pulse at %0d, expected at %0d", exp_tag[0], cyc, exp_q[0]);
          void'(exp_q.pop_front()); void'(exp_tag.pop_front());
        end else begin
          void'(exp_q.pop_front()); void'(exp_tag.pop_front());
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string tag);
    step(6);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d pending pulses, expected 0", tag, exp_q.size());
      exp_q.delete(); exp_tag.delete();
    end
  endtask

  task automatic tick(input bit expect_it, input string tag);
    @(negedge clk);
    tick_in = 1'b1;
    if (expect_it) push(cyc + 1, tag);
    @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic pin(input logic v, input bit expect_it, input string tag);
    @(negedge clk);
    pin_in = v;
    if (expect_it) push(cyc + 3, tag);
  endtask

  task automatic strobe(input bit expect_it, input string tag);
    @(negedge clk);
    strobe_2k = 1'b1;
    if (expect_it) push(cyc + 2, tag);
    @(negedge clk);
    strobe_2k = 1'b0;
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (count_en !== 1'b0) begin
      fails++;
      $display("FAIL R7: count_en after reset actual %b expected 0", count_en);
    end
    quiet("R7");

    // timer mode
    tick(1, "R1");
    step(2);
    @(negedge clk); tick_in = 1'b1; push(cyc + 1, "R1");
    @(negedge clk); push(cyc + 1, "R1");
    @(negedge clk); tick_in = 1'b0;
    quiet("R1");

    // timer mode ignores pin, polarity and filter
    pol_rise = 1'b1; filt_en = 1'b0;
    pin(1'b0, 0, "R6"); step(4);
    pin(1'b1, 0, "R6"); step(4);
    filt_en = 1'b1;
    tick(1, "R6");
    pol_rise = 1'b0; filt_en = 1'b0;
    quiet("R6");

    // event mode, no filter, falling edge
    @(negedge clk); mode_evt = 1'b1;
    quiet("R8");
    pin(1'b0, 1, "R3"); step(5);
    pin(1'b1, 0, "R2"); step(5);
    quiet("R2");
    @(negedge clk); pol_rise = 1'b1;
    quiet("R8");
    pin(1'b0, 0, "R2"); step(5);
    pin(1'b1, 1, "R2"); step(5);
    @(negedge clk); pol_rise = 1'b0;
    @(negedge clk); pol_rise = 1'b1;
    quiet("R8");

    // ticks ignored in event mode
    tick(0, "R9"); tick(0, "R9");
    quiet("R9");

    // rapid toggles, rising edges counted
    pin(1'b0, 0, "R10"); step(1);
    pin(1'b1, 1, "R10"); step(1);
    pin(1'b0, 0, "R10"); step(1);
    pin(1'b1, 1, "R10");
    quiet("R10");

    // filtered, falling edge
    @(negedge clk); pol_rise = 1'b0; filt_en = 1'b1;
    quiet("R4");
    pin(1'b0, 0, "R4"); step(4);
    strobe(0, "R4"); step(3);
    strobe(1, "R4");
    quiet("R4");
    pin(1'b1, 0, "R4"); step(4);
    strobe(0, "R4"); step(2);
    strobe(0, "R4");
    quiet("R4");

    // glitch shorter than the accept window
    pin(1'b0, 0, "R5"); step(4);
    strobe(0, "R5"); step(1);
    pin(1'b1, 0, "R5"); step(5);
    strobe(0, "R5"); step(2);
    strobe(0, "R5");
    quiet("R5");
    pin(1'b0, 0, "R5"); step(1);
    pin(1'b1, 0, "R5"); step(5);
    strobe(0, "R5"); step(2);
    strobe(0, "R5");
    quiet("R5");

    // filtered, rising edge
    @(negedge clk); pol_rise = 1'b1;
    pin(1'b0, 0, "R4"); step(4);
    strobe(0, "R4"); step(2);
    strobe(0, "R4"); step(4);
    pin(1'b1, 0, "R4"); step(4);
    strobe(0, "R4"); step(5);
    strobe(1, "R4");
    quiet("R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule